// File: doc/BRIEF.md
# Serial Program Loader with Quiet-Line Start

This block fills main memory with a program image that arrives on an asynchronous serial line, while the processor is held in reset. Each received byte is checked for a valid frame and added to a 32-bit word under assembly. When four bytes are in, the word goes out on a single-cycle memory write port. Words land at consecutive byte addresses, starting at zero and stepping by four.

The loader does not wait for a command to launch the processor. Once at least one good byte has arrived, it counts clock cycles of silence. When that silence outlasts a parameterised window (half a second of clocks by default), it drops `cpu_reset` and stops loading. The release holds until `rst` is asserted again.

Top module: `uart_boot_loader`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `cpu_reset` is 1, `mem_we` is 0 and `mem_addr` is 0.
- R2: A frame is a low start bit, eight data bits least significant first, then a stop bit. Each bit lasts CLK_HZ/BAUD clocks, and each bit is sampled near its middle.
- R3: A start bit is accepted only if the line is still low half a bit period after the falling edge. A shorter low pulse produces no byte.
- R4: If the stop bit is sampled low, `frame_err` pulses high for one cycle and the byte is dropped. It takes no part in word assembly.
- R5: Every four accepted bytes produce one write. The first byte of the four goes to bits 31:24 and the last to bits 7:0. `mem_we` is high for exactly one cycle, with `mem_wdata` valid in that cycle.
- R6: `mem_addr` is 0 after reset. It advances by 4 in the cycle after each write and otherwise holds its value.
- R7: Before any accepted byte, `cpu_reset` stays 1 however long the line is idle.
- R8: Once a byte has been accepted, `cpu_reset` falls after IDLE_CYCLES clocks with no further accepted byte. Each accepted byte restarts this count.
- R9: After release, `cpu_reset` stays 0 until `rst`. Later bytes cause no writes, and a partly assembled word is discarded.
- R10: Asserting `rst` again restores the R1 state, and a new load starts at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| rxd | input | 1 | Serial receive line; idles high |
| mem_we | output | 1 | One-cycle write strobe to main memory |
| mem_addr | output | AW | Byte address of the current write |
| mem_wdata | output | 32 | Assembled word, first received byte in the top byte |
| frame_err | output | 1 | One-cycle pulse when a frame's stop bit is low |
| cpu_reset | output | 1 | Holds the processor in reset while loading |

## Verification
Two conditions are hard to reach from the ports: the silence counter restarting, and a partly assembled word meeting the timeout. For the restart, the stimulus spaces bytes with gaps that are each below the window but together exceed it, so an early release would show. For the timeout, the stimulus sends two bytes and then goes quiet. It keeps sending after the release to show that nothing more is written. A short low glitch and a frame with a low stop bit are placed inside a word, so that any stray byte would corrupt the next expected word.

// File: rtl/uart_boot_loader.sv
module uart_boot_loader #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int BAUD        = 115_200,
  parameter int IDLE_CYCLES = CLK_HZ / 2,
  parameter int AW          = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rxd,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic          frame_err,
  output logic          cpu_reset
);
  localparam int BIT  = CLK_HZ / BAUD;
  localparam int HALF = BIT / 2;
  localparam int CW   = $clog2(BIT + 1);
  localparam int IW   = $clog2(IDLE_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;

  st_t           st;
  logic [1:0]    sync;
  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    sh;
  logic          byte_vld;
  logic [1:0]    nbytes;
  logic [23:0]   word;
  logic          got_data;
  logic [IW-1:0] idle_cnt;

  wire rx_s = sync[1];
  wire mid  = cnt == CW'(HALF - 1);
  wire last = cnt == CW'(BIT - 1);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sync      <= 2'b11;
      st        <= S_IDLE;
      cnt       <= '0;
      bitn      <= '0;
      sh        <= '0;
      byte_vld  <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      sync      <= {sync[0], rxd};
      byte_vld  <= 1'b0;
      frame_err <= 1'b0;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (!rx_s) st <= S_START;
        end
        S_START: begin
          if (mid) begin
            cnt  <= '0;
            bitn <= '0;
            st   <= rx_s ? S_IDLE : S_DATA;
          end else cnt <= cnt + CW'(1);
        end
        S_DATA: begin
          if (last) begin
            cnt  <= '0;
            sh   <= {rx_s, sh[7:1]};
            bitn <= bitn + 3'd1;
            if (bitn == 3'd7) st <= S_STOP;
          end else cnt <= cnt + CW'(1);
        end
        S_STOP: begin
          if (last) begin
            cnt <= '0;
            st  <= S_IDLE;
            if (rx_s) byte_vld  <= 1'b1;
            else      frame_err <= 1'b1;
          end else cnt <= cnt + CW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      nbytes    <= '0;
      word      <= '0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      mem_addr  <= '0;
    end else begin
      mem_we <= 1'b0;
      if (byte_vld && cpu_reset) begin
        nbytes <= nbytes + 2'd1;
        word   <= {word[15:0], sh};
        if (nbytes == 2'd3) begin
          mem_we    <= 1'b1;
          mem_wdata <= {word, sh};
        end
      end
      if (mem_we) mem_addr <= mem_addr + AW'(4);
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      got_data  <= 1'b0;
      idle_cnt  <= '0;
      cpu_reset <= 1'b1;
    end else if (byte_vld) begin
      got_data <= 1'b1;
      idle_cnt <= '0;
    end else if (got_data && cpu_reset) begin
      if (idle_cnt == IW'(IDLE_CYCLES - 1)) cpu_reset <= 1'b0;
      idle_cnt <= idle_cnt + IW'(1);
    end
  end

  assert_we_while_held_R9: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> cpu_reset);
  assert_release_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    !cpu_reset |=> !cpu_reset);
  assert_release_needs_data_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_reset) |-> got_data);
  assert_we_single_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);
  assert_addr_step_R6: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> mem_addr == $past(mem_addr) + AW'(4));
  assert_addr_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !mem_we |=> $stable(mem_addr));
endmodule

// File: tb/uart_boot_loader_bench.sv
module uart_boot_loader_bench;
  localparam int BIT  = 16;
  localparam int IDLE = 400;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rxd = 1'b1;
  logic        mem_we, frame_err, cpu_reset;
  logic [31:0] mem_addr, mem_wdata;

  uart_boot_loader #(.CLK_HZ(1_000_000), .BAUD(62_500), .IDLE_CYCLES(IDLE), .AW(32)) u_uart_boot_loader (
    .clk(clk), .rst(rst), .rxd(rxd), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .frame_err(frame_err), .cpu_reset(cpu_reset));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] wq[$];
  logic [31:0] partial = '0;
  int nb = 0, quiet = 0, exp_err = 0, seen_err = 0;
  logic [31:0] exp_addr = '0;
  bit seen_data = 0, exp_rel = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst) begin
    quiet++;
    if (frame_err) seen_err++;
    if (!exp_rel && seen_data && quiet > IDLE + 2 * BIT) begin
      exp_rel = 1;
      nb = 0;
    end
    if (exp_rel) check(cpu_reset == 1'b0, "R9", "cpu_reset after release", cpu_reset, 0);
    else if (!seen_data) check(cpu_reset == 1'b1, "R7", "cpu_reset before data", cpu_reset, 1);
    else if (quiet < IDLE) check(cpu_reset == 1'b1, "R8", "cpu_reset inside window", cpu_reset, 1);
    if (mem_we) begin
      check(wq.size() != 0, "R5", "unexpected write", mem_wdata, 0);
      if (wq.size() != 0) begin
        logic [31:0] w;
        w = wq.pop_front();
        check(mem_wdata == w, "R5", "write data", mem_wdata, w);
        check(mem_addr == exp_addr, "R6", "write address", mem_addr, exp_addr);
        exp_addr += 4;
      end
    end
  end

  task automatic send_byte(input logic [7:0] b, input bit good);
    @(negedge clk) rxd = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (BIT) @(negedge clk);
    end
    if (good && !exp_rel) begin
      seen_data = 1;
      quiet = 0;
      partial = {partial[23:0], b};
      nb++;
      if (nb == 4) begin
        wq.push_back(partial);
        nb = 0;
      end
    end
    if (!good) exp_err++;
    rxd = good;
    repeat (BIT) @(negedge clk);
    rxd = 1'b1;
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drained(input string req);
    gap(20);
    check(wq.size() == 0, req, "pending expected writes", wq.size(), 0);
  endtask

  task automatic do_reset;
    @(negedge clk) rst = 1'b1;
    gap(3);
    wq.delete();
    nb = 0; quiet = 0; exp_addr = 0; seen_data = 0; exp_rel = 0;
    rst = 1'b0;
    @(negedge clk);
    check(cpu_reset == 1'b1, "R1", "cpu_reset after reset", cpu_reset, 1);
    check(mem_we == 1'b0, "R1", "mem_we after reset", mem_we, 0);
    check(mem_addr == 0, "R1", "mem_addr after reset", mem_addr, 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    // R7: long silence with no data keeps the CPU held
    gap(2 * IDLE);
    check(cpu_reset == 1'b1, "R7", "held after idle without data", cpu_reset, 1);
    // R2 R5: plain word, varied gaps
    send_byte(8'h12, 1); gap(5);
    send_byte(8'h34, 1); send_byte(8'h56, 1); gap(50);
    send_byte(8'h78, 1);
    drained("R2");
    // R4: bad stop bit in the middle of a word is dropped
    send_byte(8'hC3, 1); send_byte(8'hFF, 0); gap(3);
    send_byte(8'h3C, 1); send_byte(8'h81, 1); send_byte(8'h7E, 1);
    drained("R4");
    // R3: short low glitch produces no byte
    @(negedge clk) rxd = 1'b0; gap(BIT / 2 - 2); rxd = 1'b1; gap(2 * BIT);
    send_byte(8'h00, 1); send_byte(8'hFF, 1); send_byte(8'h01, 1); send_byte(8'h80, 1);
    drained("R3");
    // R8: gaps below the window each restart the silence count
    gap(200); send_byte(8'hDE, 1);
    gap(200); send_byte(8'hAD, 1);
    gap(200); send_byte(8'hBE, 1); send_byte(8'hEF, 1);
    drained("R8");
    // R9: partial word then timeout; later bytes ignored
    send_byte(8'h11, 1); send_byte(8'h22, 1);
    gap(IDLE + 3 * BIT);
    check(cpu_reset == 1'b0, "R8", "released after silence", cpu_reset, 0);
    for (int i = 0; i < 4; i++) send_byte(8'h40 + 8'(i), 1);
    drained("R9");
    check(cpu_reset == 1'b0, "R9", "still released", cpu_reset, 0);
    check(seen_err == exp_err, "R4", "frame error pulses", seen_err, exp_err);
    // R10: a new reset starts a fresh load at address 0
    do_reset();
    send_byte(8'h9A, 1); send_byte(8'hBC, 1); send_byte(8'hDE, 1); send_byte(8'hF0, 1);
    drained("R10");
    gap(IDLE + 3 * BIT);
    check(cpu_reset == 1'b0, "R10", "released after second load", cpu_reset, 0);
    finish_run();
  end
endmodule